// File: doc/BRIEF.md
# Row-Stationary Convolution Array

This block computes a two-dimensional convolution of a 3x3 filter over a five-row, seven-column signed feature map and produces three output rows of five values each. The work is split across a 3x3 grid of processing elements. Each element handles one one-dimensional row convolution. It holds one filter row and one feature-map row in local registers, and it accumulates that row's partial sum locally, one tap per cycle.

Grid row r takes filter row r, and grid column j takes output row j. The element at (r, j) reads feature-map row r+j, counting from zero, so one feature-map row serves every element on a diagonal and one filter row serves every element in a grid row. When all three taps of a window position have been accumulated, the three partial sums in each grid column are added together. The three column sums for that position are then presented together as one output beat.

Rows arrive one at a time on a valid/ready load port. A start pulse runs the array over all five window positions. Results leave on a valid/ready stream, one beat per window position. Each beat is tagged with its column index and carries one lane per output row. When the consumer holds ready low, the array freezes in place until the beat is taken.

Top module: `rs_conv_array`

## Requirements
- R1: After reset, `out_valid` is 0 and `ld_ready` is 1.
- R2: While a run is in progress, `ld_ready` is 0 and rows offered on the load port are not taken. A row is taken only on a cycle where `ld_valid` and `ld_ready` are both 1.
- R3: A start is granted only when no run is in progress and, since the last granted start, every filter row (kind 1, index 0..2) and every feature-map row (kind 0, index 0..4) has been loaded. Any other start has no effect. A granted start clears the loaded record, and rows already held in the elements stay in place.
- R4: Lane j of the beat tagged column x equals sum over r=0..2 and k=0..2 of F[r][k]*M[r+j][x+k]. Here F is the filter, M is the feature map, and element e of a loaded row is `ld_row[8e+7:8e]`, read as two's complement.
- R5: Each granted start yields exactly five beats, tagged 0, 1, 2, 3, 4 in that order, and no further beat.
- R6: While `out_valid` is 1 and `out_ready` is 0, the beat stays valid and its tag and lanes do not change on the next cycle. A beat is never overwritten before it is taken.
- R7: With `out_ready` held at 1, the first beat is valid after the fourth rising edge that follows the edge sampling the granted start. Each later beat follows three edges after the previous one.
- R8: Results over the full input range come out exactly. Element partial sums stay within plus or minus 49152, and lanes stay within plus or minus 147456. For example, all-(-128) inputs give 147456 in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A row is offered on the load port |
| ld_ready | output | 1 | The load port can take a row (no run in progress) |
| ld_kind | input | 1 | 1 = filter row, 0 = feature-map row |
| ld_index | input | 3 | Row index: filter 0..2, feature map 0..4 |
| ld_row | input | 56 | Packed row, element e in bits [8e+7:8e]; a filter uses elements 0..2 |
| start | input | 1 | Request a run, one cycle |
| out_valid | output | 1 | A result beat is available |
| out_ready | input | 1 | The consumer takes the beat |
| out_col | output | 3 | Column tag 0..4 of the beat |
| out_sums | output | 66 | Three signed 22-bit lanes, lane j in bits [22j+21:22j] = output row j |

## Verification
The range checks on partial sums and lanes rely on every loaded element being an 8-bit two's-complement value and on each run covering exactly three taps per position. The stimulus keeps to that by drawing every element from -128..127, with directed extremes at -128 and 127. The no-overwrite and hold checks assume the consumer keeps `out_ready` constant between clock edges. The stimulus changes it only at falling edges, sometimes at random and sometimes held high. The start-gating check assumes no row is loaded in the cycle a start is granted. The stimulus never loads in that cycle, and it never offers load indices outside the ranges listed above.

// File: rtl/rs_conv_pkg.sv
`timescale 1ns/1ps
package rs_conv_pkg;
  parameter int DATA_W   = 8;   // input element width
  parameter int KW       = 3;   // filter size (rows and taps)
  parameter int FMAP_W   = 7;   // feature-map row length
  parameter int OUT_ROWS = 3;   // output rows = grid columns
  parameter int PSUM_W   = 20;  // element partial-sum width
  parameter int CSUM_W   = 22;  // column-sum width
endpackage

// File: rtl/rs_row_pe.sv
`timescale 1ns/1ps
module rs_row_pe
  import rs_conv_pkg::*;
#(
  parameter int K   = KW,
  parameter int FW  = FMAP_W,
  parameter int DW  = DATA_W,
  parameter int PSW = PSUM_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        filt_we,
  input  logic                        fmap_we,
  input  logic [FW*DW-1:0]            ld_row,
  input  logic                        step,
  input  logic [$clog2(K)-1:0]        tap,
  input  logic [$clog2(FW-K+1)-1:0]   pos,
  output logic signed [PSW-1:0]       psum
);
  localparam int OW   = FW - K + 1;
  localparam int PW   = $clog2(OW);
  localparam int IW   = $clog2(FW);
  localparam int PRW  = 2 * DW;
  localparam int PMAX = K * (1 << (2 * DW - 2));

  logic signed [DW-1:0]  filt_q [K];
  logic signed [DW-1:0]  win_q  [FW];
  logic signed [PSW-1:0] psum_q;
  logic [IW-1:0]         sel;
  logic signed [PRW-1:0] prod;
  logic signed [PSW-1:0] prod_ext;

  assign sel      = IW'(pos) + IW'(tap);
  assign prod     = filt_q[tap] * win_q[sel];
  assign prod_ext = {{(PSW-PRW){prod[PRW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < K; k++)  filt_q[k] <= '0;
      for (int e = 0; e < FW; e++) win_q[e]  <= '0;
      psum_q <= '0;
    end else begin
      if (filt_we)
        for (int k = 0; k < K; k++)  filt_q[k] <= ld_row[k*DW +: DW];
      if (fmap_we)
        for (int e = 0; e < FW; e++) win_q[e]  <= ld_row[e*DW +: DW];
      if (step)
        psum_q <= (tap == '0) ? prod_ext : psum_q + prod_ext;
    end
  end

  assign psum = psum_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(psum_q) <= PMAX) && (int'(psum_q) >= -PMAX));
endmodule

// File: rtl/rs_col_sum.sv
`timescale 1ns/1ps
module rs_col_sum
  import rs_conv_pkg::*;
#(
  parameter int K   = KW,
  parameter int DW  = DATA_W,
  parameter int PSW = PSUM_W,
  parameter int CSW = CSUM_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [K*PSW-1:0]      psums,
  output logic signed [CSW-1:0] sum_q
);
  localparam int SMAX = K * K * (1 << (2 * DW - 2));

  logic signed [CSW-1:0] sum_d;

  always_comb begin
    sum_d = '0;
    for (int r = 0; r < K; r++)
      sum_d = sum_d + {{(CSW-PSW){psums[r*PSW+PSW-1]}}, psums[r*PSW +: PSW]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum_q <= '0;
    else if (take) sum_q <= sum_d;
  end

  assert_sum_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sum_q) <= SMAX) && (int'(sum_q) >= -SMAX));
endmodule

// File: rtl/rs_seq_ctrl.sv
`timescale 1ns/1ps
module rs_seq_ctrl
  import rs_conv_pkg::*;
#(
  parameter int K    = KW,
  parameter int FW   = FMAP_W,
  parameter int NCOL = OUT_ROWS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          ld_fire,
  input  logic                          ld_kind,
  input  logic [$clog2(K+NCOL-1)-1:0]   ld_index,
  input  logic                          out_ready,
  output logic                          busy,
  output logic                          step,
  output logic [$clog2(K)-1:0]          tap,
  output logic [$clog2(FW-K+1)-1:0]     pos,
  output logic                          take,
  output logic                          out_valid,
  output logic [$clog2(FW-K+1)-1:0]     out_col
);
  localparam int NIN = K + NCOL - 1;
  localparam int OW  = FW - K + 1;
  localparam int PW  = $clog2(OW);
  localparam int TW  = $clog2(K);

  logic [K-1:0]   seen_f;
  logic [NIN-1:0] seen_m;
  logic [PW-1:0]  take_pos;
  logic           go;

  assign go   = start && !busy && (&seen_f) && (&seen_m);
  assign step = busy && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_f <= '0;
      seen_m <= '0;
      busy   <= 1'b0;
      pos    <= '0;
      tap    <= '0;
    end else if (go) begin
      seen_f <= '0;
      seen_m <= '0;
      busy   <= 1'b1;
      pos    <= '0;
      tap    <= '0;
    end else begin
      if (ld_fire) begin
        if (ld_kind && int'(ld_index) < K)     seen_f[ld_index] <= 1'b1;
        if (!ld_kind && int'(ld_index) < NIN)  seen_m[ld_index] <= 1'b1;
      end
      if (step) begin
        if (tap == TW'(K-1)) begin
          tap <= '0;
          if (pos == PW'(OW-1)) busy <= 1'b0;
          else                  pos  <= pos + 1'b1;
        end else begin
          tap <= tap + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      take_pos  <= '0;
      out_valid <= 1'b0;
      out_col   <= '0;
    end else begin
      take <= step && (tap == TW'(K-1));
      if (step && tap == TW'(K-1)) take_pos <= pos;
      if (take) begin
        out_valid <= 1'b1;
        out_col   <= take_pos;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past((&seen_f) && (&seen_m)));

  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !out_valid);
endmodule

// File: rtl/rs_conv_array.sv
`timescale 1ns/1ps
module rs_conv_array
  import rs_conv_pkg::*;
#(
  parameter int K    = KW,
  parameter int FW   = FMAP_W,
  parameter int NCOL = OUT_ROWS,
  parameter int DW   = DATA_W,
  parameter int PSW  = PSUM_W,
  parameter int CSW  = CSUM_W,
  localparam int NIN = K + NCOL - 1,
  localparam int LIW = $clog2(NIN),
  localparam int PW  = $clog2(FW - K + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic                 ld_kind,
  input  logic [LIW-1:0]       ld_index,
  input  logic [FW*DW-1:0]     ld_row,
  input  logic                 start,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PW-1:0]        out_col,
  output logic [NCOL*CSW-1:0]  out_sums
);
  localparam int TW = $clog2(K);

  logic          busy, step, take, ld_fire;
  logic [TW-1:0] tap;
  logic [PW-1:0] pos;

  assign ld_ready = !busy;
  assign ld_fire  = ld_valid && ld_ready;

  rs_seq_ctrl #(.K(K), .FW(FW), .NCOL(NCOL)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_fire(ld_fire),
    .ld_kind(ld_kind), .ld_index(ld_index), .out_ready(out_ready),
    .busy(busy), .step(step), .tap(tap), .pos(pos), .take(take),
    .out_valid(out_valid), .out_col(out_col)
  );

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    logic [K*PSW-1:0]      col_ps;
    logic signed [CSW-1:0] col_sum;

    for (genvar r = 0; r < K; r++) begin : g_pe
      logic                  f_we, m_we;
      logic signed [PSW-1:0] ps;
      assign f_we = ld_fire &&  ld_kind && (ld_index == LIW'(r));
      assign m_we = ld_fire && !ld_kind && (ld_index == LIW'(r + j));
      rs_row_pe #(.K(K), .FW(FW), .DW(DW), .PSW(PSW)) pe_i (
        .clk(clk), .rst_n(rst_n), .filt_we(f_we), .fmap_we(m_we),
        .ld_row(ld_row), .step(step), .tap(tap), .pos(pos), .psum(ps)
      );
      assign col_ps[r*PSW +: PSW] = ps;
    end

    rs_col_sum #(.K(K), .DW(DW), .PSW(PSW), .CSW(CSW)) sum_i (
      .clk(clk), .rst_n(rst_n), .take(take), .psums(col_ps), .sum_q(col_sum)
    );
    assign out_sums[j*CSW +: CSW] = col_sum;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sums) && $stable(out_col)));
endmodule

// File: tb/rs_conv_array_tb_top.sv
`timescale 1ns/1ps
module rs_conv_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_kind = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [2:0]  ld_index = '0;
  logic [55:0] ld_row = '0;
  logic        ld_ready, out_valid;
  logic [2:0]  out_col;
  logic [65:0] out_sums;

  int n_checks = 0;
  int n_fail   = 0;
  int fr [3][3];
  int fm [5][7];

  always #5 clk = ~clk;

  rs_conv_array dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_kind(ld_kind), .ld_index(ld_index), .ld_row(ld_row), .start(start),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
    .out_sums(out_sums)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_val(input int j, input int x);
    int s = 0;
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 3; k++)
        s += fr[r][k] * fm[r+j][x+k];
    return s;
  endfunction

  function automatic int lane(input int j);
    logic signed [21:0] v;
    v = out_sums[22*j +: 22];
    return int'(v);
  endfunction

  task automatic load_row(input bit kind, input int idx);
    logic [55:0] row = '0;
    @(negedge clk);
    for (int e = 0; e < 7; e++) begin
      if (kind && e < 3) row[8*e +: 8] = 8'(fr[idx][e]);
      else if (!kind)    row[8*e +: 8] = 8'(fm[idx][e]);
    end
    ld_valid = 1'b1; ld_kind = kind; ld_index = 3'(idx); ld_row = row;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic load_all();
    for (int r = 0; r < 3; r++) load_row(1'b1, r);
    for (int i = 0; i < 5; i++) load_row(1'b0, i);
  endtask

  task automatic fill(input int mode, input int fv, input int mv);
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 3; k++) fr[r][k] = mode ? fv : int'($urandom % 256) - 128;
    for (int i = 0; i < 5; i++)
      for (int e = 0; e < 7; e++) fm[i][e] = mode ? mv : int'($urandom % 256) - 128;
  endtask

  // ready_mode: 0 random back-pressure, 1 always ready; poke: offer junk loads mid-run
  task automatic run(input bit ready_mode, input bit poke, input string tag);
    int got = 0, cyc = 0;
    bit stall = 0;
    logic [65:0] h_sums;
    logic [2:0]  h_col;
    @(negedge clk);
    start = 1'b1;
    out_ready = ready_mode ? 1'b1 : 1'b0;
    while (got < 5 && cyc < 400) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke) begin
        ld_valid = (cyc >= 1 && cyc < 15);
        ld_kind = 1'b1; ld_index = 3'd0; ld_row = {7{8'h55}};
      end
      if (cyc == 2) check(ld_ready == 1'b0, "R2 ld_ready low in run", int'(ld_ready), 0);
      if (stall) begin
        check(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
        check(out_sums == h_sums && out_col == h_col, "R6 beat stable",
              int'(out_col), int'(h_col));
      end
      out_ready = ready_mode ? 1'b1 : ($urandom % 3 != 0);
      stall = out_valid && !out_ready;
      h_sums = out_sums; h_col = out_col;
      if (out_valid && out_ready) begin
        check(int'(out_col) == got, {"R5 tag ", tag}, int'(out_col), got);
        for (int j = 0; j < 3; j++)
          check(lane(j) == ref_val(j, got), {"R4 lane ", tag}, lane(j), ref_val(j, got));
        if (ready_mode)
          check(cyc == 5 + 3 * got, "R7 beat timing", cyc, 5 + 3 * got);
        got++;
      end
    end
    ld_valid = 1'b0;
    check(got == 5, {"R5 beat count ", tag}, got, 5);
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      if (out_valid) check(1'b0, "R5 extra beat", 1, 0);
    end
    check(ld_ready == 1'b1, "R2 ld_ready after run", int'(ld_ready), 1);
    out_ready = 1'b0;
  endtask

  task automatic expect_ignored(input string req);
    bit seen_v = 0, seen_busy = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    out_ready = 1'b1;
    for (int w = 0; w < 20; w++) begin
      if (out_valid) seen_v = 1;
      if (!ld_ready) seen_busy = 1;
      @(negedge clk);
    end
    check(!seen_v && !seen_busy, req, int'(seen_v) + int'(seen_busy), 0);
    out_ready = 1'b0;
  endtask

  task automatic finish_all();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        finish_all();
      end
    end
  end

  initial begin
    process::self().srandom(32'd1177);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid reset", int'(out_valid), 0);
    check(ld_ready == 1'b1, "R1 ld_ready reset", int'(ld_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: one feature-map row missing -> start has no effect
    fill(0, 0, 0);
    for (int r = 0; r < 3; r++) load_row(1'b1, r);
    for (int i = 0; i < 4; i++) load_row(1'b0, i);
    expect_ignored("R3 start without row 4");
    load_row(1'b0, 4);
    run(1'b0, 1'b0, "first random");

    // R3: restart without reload is ignored
    expect_ignored("R3 start without reload");

    // R7 timing with always-ready, and R2 junk loads offered mid-run
    fill(0, 0, 0);
    load_all();
    run(1'b1, 1'b1, "timed poke");

    // R8 extremes
    fill(1, -128, -128);
    load_all();
    run(1'b1, 1'b0, "all min");
    check(ref_val(0, 0) == 147456, "R8 model max", ref_val(0, 0), 147456);
    fill(1, 127, -128);
    load_all();
    run(1'b0, 1'b0, "mixed extreme");
    fill(1, 0, 0);
    load_all();
    run(1'b0, 1'b0, "zeros");

    // R3: reload only some rows after a run -> still ignored
    for (int r = 0; r < 3; r++) load_row(1'b1, r);
    expect_ignored("R3 partial reload");

    for (int t = 0; t < 8; t++) begin
      fill(0, 0, 0);
      load_all();
      run(t[0], 1'b0, "random");
    end
    finish_all();
  end
endmodule